// File: doc/BRIEF.md
# SM3 Message Expansion Half-Step Unit

This block computes the first half of one SM3 message-expansion step over 128-bit vectors. Three operands arrive together. Each operand holds four 32-bit words: an accumulator vector, an auxiliary vector and a rotate-source vector. The result replaces the accumulator. Each word of the result is formed from XORs and fixed left rotations, then passed through the SM3 P1 permutation. The topmost word does not stand alone. It is built from the already permuted bottom word, so the lanes form a chain rather than four parallel paths.

The unit sits behind a valid/ready handshake with one output register. An accepted operand set produces its result exactly one clock later. A stalled result holds still until the consumer takes it. When the output is free or being drained, a new operand set can enter in the same cycle. No data value alters timing.

Top module: `sm3x_expand_half`

## Requirements
- R1: Lane i is bits 32*i+31..32*i, with lane 0 in the least significant bits. For lanes 0, 1 and 2, the pre-permutation value is (acc XOR aux) in that lane, XORed with rotl(rot-source lane i+1, 15).
- R2: Every result lane equals P1 of its pre-permutation value, where P1(x) = x ^ rotl(x,15) ^ rotl(x,23).
- R3: The pre-permutation value of lane 3 is (acc XOR aux) lane 3 XORed with rotl(result lane 0, 15). Here result lane 0 is the value after P1.
- R4: Lane 0 of the rotate-source operand (bits 31:0) has no effect on the result.
- R5: An operand set accepted on a clock edge (in_valid and in_ready both high) gives out_valid high with its result after exactly that edge. The latency is independent of the data.
- R6: While out_valid is high and out_ready is low, out_data and out_valid hold, and in_ready is low.
- R7: If the output is drained (out_ready high) and no operand set is accepted on the same edge, out_valid is low after the edge.
- R8: Synchronous active-high reset clears out_valid. in_ready is high after reset.
- R9: In a cycle where the output is drained and a new operand set is offered, the new set is accepted. This sustains one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit can take an operand set |
| in_acc | input | 128 | Accumulator operand, replaced by the result |
| in_aux | input | 128 | Auxiliary operand XORed into every lane |
| in_rot | input | 128 | Rotate-source operand; lanes 1..3 feed lanes 0..2 |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Result vector |

## Verification
Two events can fall on the same edge: the output register drains, and a new operand set is accepted into it. The bench provokes this by streaming vectors back to back with out_ready held high. It then releases a stall while a fresh set is already waiting at the input. In each case the bench judges the result at the next falling edge. It expects the new vector's reference value, with out_valid still high and no bubble. The stall phase itself is judged by comparing out_data against the value captured before the stall began.

// File: rtl/sm3x_pkg.sv
package sm3x_pkg;
   // Width of one word lane and the number of lanes in a vector
   localparam int unsigned LANE_W  = 32;
   localparam int unsigned N_LANES = 4;
   localparam int unsigned VEC_W   = LANE_W * N_LANES;

   typedef logic [LANE_W-1:0] lane_t;
   typedef logic [VEC_W-1:0]  vec_t;
endpackage

// File: rtl/sm3x_p1.sv
// SM3 P1 permutation on a single lane: x ^ rotl(x,A) ^ rotl(x,B)
module sm3x_p1 #(
   parameter int unsigned W     = 32,
   parameter int unsigned ROT_A = 15,
   parameter int unsigned ROT_B = 23
) (
   input  logic [W-1:0] x_i,
   output logic [W-1:0] y_o
);
   initial begin
      p1_rot_range_chk: assert (ROT_A > 0 && ROT_A < W && ROT_B > 0 && ROT_B < W)
         else $fatal(1, "sm3x_p1: rotation amounts must lie in 1..W-1");
   end

   logic [W-1:0] rot_a;
   logic [W-1:0] rot_b;

   always_comb begin
      rot_a = (x_i << ROT_A) | (x_i >> (W - ROT_A));
      rot_b = (x_i << ROT_B) | (x_i >> (W - ROT_B));
      y_o   = x_i ^ rot_a ^ rot_b;
   end
endmodule

// File: rtl/sm3x_lane_mix.sv
// Combinational lane network: lanes 0..LANES-2 draw on the rotate source,
// the top lane draws on the permuted lane 0.
module sm3x_lane_mix #(
   parameter int unsigned LANE_W   = 32,
   parameter int unsigned LANES    = 4,
   parameter int unsigned ROT_SRC  = 15,
   parameter int unsigned ROT_LINK = 15,
   parameter int unsigned P1_A     = 15,
   parameter int unsigned P1_B     = 23
) (
   input  logic [LANE_W*LANES-1:0] acc_i,
   input  logic [LANE_W*LANES-1:0] aux_i,
   input  logic [LANE_W*LANES-1:0] rot_i,
   output logic [LANE_W*LANES-1:0] res_o
);
   localparam int unsigned LOW_N = LANES - 1;

   initial begin
      mix_shape_chk: assert (LANES >= 2 && ROT_SRC > 0 && ROT_SRC < LANE_W &&
                             ROT_LINK > 0 && ROT_LINK < LANE_W)
         else $fatal(1, "sm3x_lane_mix: illegal lane count or rotation");
   end

   logic [LANE_W*LANES-1:0] dn;
   assign dn = acc_i ^ aux_i;

   logic [LANE_W-1:0] low_pre  [LOW_N];
   logic [LANE_W-1:0] low_perm [LOW_N];

   // R1: lane i mixes with rotate-source lane i+1; rotate-source lane 0 is unused (R4)
   for (genvar i = 0; i < LOW_N; i++) begin : g_low
      logic [LANE_W-1:0] src_w;
      assign src_w      = rot_i[LANE_W*(i+1) +: LANE_W];
      assign low_pre[i] = dn[LANE_W*i +: LANE_W] ^
                          ((src_w << ROT_SRC) | (src_w >> (LANE_W - ROT_SRC)));

      // R2
      sm3x_p1 #(.W(LANE_W), .ROT_A(P1_A), .ROT_B(P1_B)) u_p1 (
         .x_i (low_pre[i]),
         .y_o (low_perm[i])
      );

      assign res_o[LANE_W*i +: LANE_W] = low_perm[i];
   end

   // R3: the top lane is chained to the permuted bottom lane
   logic [LANE_W-1:0] link_w;
   logic [LANE_W-1:0] top_pre;
   logic [LANE_W-1:0] top_perm;

   assign link_w  = low_perm[0];
   assign top_pre = dn[LANE_W*LOW_N +: LANE_W] ^
                    ((link_w << ROT_LINK) | (link_w >> (LANE_W - ROT_LINK)));

   sm3x_p1 #(.W(LANE_W), .ROT_A(P1_A), .ROT_B(P1_B)) u_p1_top (
      .x_i (top_pre),
      .y_o (top_perm)
   );

   assign res_o[LANE_W*LOW_N +: LANE_W] = top_perm;
endmodule

// File: rtl/sm3x_out_stage.sv
// Single output register with valid/ready flow control.
module sm3x_out_stage #(
   parameter int unsigned W = 128
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   initial begin
      stage_width_chk: assert (W > 0) else $fatal(1, "sm3x_out_stage: W must be positive");
   end

   logic take;

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
      end else if (take) begin
         out_valid <= 1'b1;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (take) begin
         out_data <= in_data;
      end
   end

   // R8
   reset_clears_valid_chk: assert property (@(posedge clk) rst |=> !out_valid);

   // R5
   accept_gives_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

   // R6
   stall_holds_output_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R7
   drain_empties_chk: assert property (@(posedge clk) disable iff (rst)
      (out_ready && !(in_valid && in_ready)) |=> !out_valid);
endmodule

// File: rtl/sm3x_expand_half.sv
module sm3x_expand_half
   import sm3x_pkg::*;
#(
   parameter int unsigned ROT_SRC  = 15,
   parameter int unsigned ROT_LINK = 15,
   parameter int unsigned P1_A     = 15,
   parameter int unsigned P1_B     = 23
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [VEC_W-1:0] in_acc,
   input  logic [VEC_W-1:0] in_aux,
   input  logic [VEC_W-1:0] in_rot,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [VEC_W-1:0] out_data
);
   vec_t mixed;

   sm3x_lane_mix #(
      .LANE_W   (LANE_W),
      .LANES    (N_LANES),
      .ROT_SRC  (ROT_SRC),
      .ROT_LINK (ROT_LINK),
      .P1_A     (P1_A),
      .P1_B     (P1_B)
   ) u_mix (
      .acc_i (in_acc),
      .aux_i (in_aux),
      .rot_i (in_rot),
      .res_o (mixed)
   );

   sm3x_out_stage #(.W(VEC_W)) u_stage (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (mixed),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data)
   );

   // R9
   drain_and_fill_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && in_valid) |=> out_valid);
endmodule

// File: tb/tb_sm3x_expand_half.sv
module tb_sm3x_expand_half;
   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid, in_ready, out_valid, out_ready;
   logic [127:0] in_acc, in_aux, in_rot, out_data;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sm3x_expand_half dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_acc(in_acc), .in_aux(in_aux), .in_rot(in_rot),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   function automatic logic [31:0] rl(input logic [31:0] x, input int n);
      return (x << n) | (x >> (32 - n));
   endfunction

   function automatic logic [31:0] p1(input logic [31:0] x);
      return x ^ rl(x, 15) ^ rl(x, 23);
   endfunction

   function automatic logic [127:0] model(input logic [127:0] d, input logic [127:0] n,
                                          input logic [127:0] m);
      logic [127:0] x;
      logic [127:0] r;
      x = d ^ n;
      for (int i = 0; i < 3; i++)
         r[32*i +: 32] = p1(x[32*i +: 32] ^ rl(m[32*(i+1) +: 32], 15));
      r[96 +: 32] = p1(x[96 +: 32] ^ rl(r[31:0], 15));
      return r;
   endfunction

   task automatic chk(input logic ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // acc, aux, rot
   localparam logic [383:0] VECS [6] = '{
      {128'h0, 128'h0, 128'h0},
      {{4{32'hFFFF_FFFF}}, 128'h0, {4{32'hFFFF_FFFF}}},
      {128'h0000_0000_0000_0000_0000_0000_0000_0001, 128'h0, 128'h0},
      {128'h0, 128'h0, 128'h0000_0001_0000_0000_0000_0000_0000_0000},
      {128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128'h0F0F_0F0F_F0F0_F0F0_3333_3333_CCCC_CCCC,
       128'hDEAD_BEEF_CAFE_F00D_1357_9BDF_2468_ACE0},
      {128'h8000_0000_0000_0000_0000_0000_8000_0000, 128'h1, 128'h0000_8000_4000_2000_1000_0000}
   };

   task automatic one(input logic [127:0] d, input logic [127:0] n, input logic [127:0] m,
                      input string req);
      in_acc = d; in_aux = n; in_rot = m; in_valid = 1'b1; out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid, {req, " R5 valid"}, {127'b0, out_valid}, 128'h1);
      chk(out_data == model(d, n, m), req, out_data, model(d, n, m));
   endtask

   initial begin
      #1_000_000;
      errors++; checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [127:0] held, ref0, ref1;
      rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
      in_acc = '0; in_aux = '0; in_rot = '0;
      repeat (3) @(negedge clk);
      // R8
      chk(!out_valid, "R8 out_valid in reset", {127'b0, out_valid}, 128'h0);
      rst = 1'b0;
      @(negedge clk);
      chk(in_ready && !out_valid, "R8 ready after reset", {126'b0, in_ready, out_valid}, 128'h2);

      // R1 R2 R3 table walk
      for (int k = 0; k < 6; k++)
         one(VECS[k][383:256], VECS[k][255:128], VECS[k][127:0], "R1 R2 R3 table");

      // R7: drained, nothing new
      @(negedge clk);
      chk(!out_valid, "R7 drained", {127'b0, out_valid}, 128'h0);

      // R3: only acc lane 0 set must reach lane 3 through the chain
      one(128'h1, 128'h0, 128'h0, "R3 chain");
      chk(out_data[127:96] == p1(rl(p1(32'h1), 15)), "R3 top lane", out_data,
          {p1(rl(p1(32'h1), 15)), 96'h0});

      // R4: rot lane 0 has no effect
      one(VECS[4][383:256], VECS[4][255:128], VECS[4][127:0] & ~128'hFFFF_FFFF, "R4 base");
      ref0 = out_data;
      for (int b = 0; b < 32; b += 7) begin
         one(VECS[4][383:256], VECS[4][255:128], (VECS[4][127:0] & ~128'hFFFF_FFFF) | (128'h1 << b),
             "R4 bit");
         chk(out_data == ref0, "R4 rot lane0 ignored", out_data, ref0);
      end
      one(128'h0, 128'h0, 128'hFFFF_FFFF, "R4 ones");
      chk(out_data == 128'h0, "R4 lane0 ones", out_data, 128'h0);

      // R9: streaming back to back, random data (R5 fixed latency)
      ref1 = '0;
      for (int k = 0; k < 24; k++) begin
         logic [127:0] d, n, m;
         d = {$urandom, $urandom, $urandom, $urandom};
         n = {$urandom, $urandom, $urandom, $urandom};
         m = {$urandom, $urandom, $urandom, $urandom};
         in_acc = d; in_aux = n; in_rot = m; in_valid = 1'b1; out_ready = 1'b1;
         @(negedge clk);
         chk(out_valid && in_ready, "R9 stream valid", {126'b0, out_valid, in_ready}, 128'h3);
         chk(out_data == model(d, n, m), "R9 R5 stream data", out_data, model(d, n, m));
      end

      // R6: stall with a new set waiting
      held = out_data;
      out_ready = 1'b0;
      in_acc = {4{32'h5A5A_A5A5}}; in_aux = 128'h77; in_rot = {4{32'h1234_8765}};
      ref1 = model(in_acc, in_aux, in_rot);
      repeat (3) begin
         @(negedge clk);
         chk(out_valid && !in_ready, "R6 stall flags", {126'b0, out_valid, in_ready}, 128'h2);
         chk(out_data == held, "R6 stall data", out_data, held);
      end
      // R9: release stall while new set waits
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid, "R9 no bubble", {127'b0, out_valid}, 128'h1);
      chk(out_data == ref1, "R9 waiting set taken", out_data, ref1);
      @(negedge clk);
      chk(!out_valid, "R7 empty after drain", {127'b0, out_valid}, 128'h0);

      // R8: reset mid-stream
      in_valid = 1'b1; out_ready = 1'b0;
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0;
      @(negedge clk);
      chk(!out_valid, "R8 reset clears", {127'b0, out_valid}, 128'h0);
      rst = 1'b0;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule